// File: doc/BRIEF.md
# Timer/Event Counter with Pulse-Width Capture

This block is an 8-bit up-counter with three working modes. In timer mode it counts a prescaled clock-source tick. In event mode it counts edges on an external pin. In capture mode it measures how long a pulse on that pin lasts. The counter starts from a preload value. When it wraps past its maximum it reloads that value, raises a sticky overflow flag and emits a one-cycle overflow pulse. A frequency-divider output toggles on every overflow of a selectable source: this timer or a partner timer's overflow pulse. That gives a square wave at half the overflow rate.

Software writes the enable bit, the preload value and the flag-clear through strobes. The mode, edge polarity, prescaler ratio and divider source are plain level inputs. In capture mode the block clears its own enable when the pulse ends. The measured width then stays on the count output until software rearms the block.

Top module: `pulse_timer`

## Requirements
- R1: After reset the count is 0, and the overflow flag, divider output and enable are all 0.
- R2: Timer mode (mode code 01) counts the tick input through a prescaler. With select value s (0 to 7), the count advances once every 2^s ticks. The first advance comes on the 2^s-th tick after enable goes high.
- R3: Event mode (mode code 10) counts rising pin edges when edge select is 0 and falling pin edges when it is 1. The pin passes through a two-flop synchroniser. A pin change set up before clock edge k shows on the count after edge k+2.
- R4: Capture mode (mode code 11) measures a pulse. With edge select 0 the pulse opens on a falling pin edge and closes on the next rising edge; edge select 1 swaps the two. The count advances on each prescaled tick from the opening edge up to, but not including, the closing edge. With prescaler 0 and a steady tick, a pin held at its pulse level for L clock cycles yields L.
- R5: At the closing edge of a capture, the enable clears itself and the count holds. Later pin pulses leave the count unchanged.
- R6: A count step taken at 0xFF reloads the preload register, sets the overflow flag and pulses the overflow output.
- R7: The overflow flag stays set until the clear strobe. An overflow in the same cycle as the clear strobe leaves the flag set.
- R8: The divider output toggles once for each overflow of the selected source. Divider select 0 picks this timer's overflow; divider select 1 picks the peer overflow input. Overflows of the source that is not selected have no effect on it.
- R9: While the enable is 0, ticks and pin edges leave the count unchanged in every mode.
- R10: A preload write while the enable is 0 also loads the count at the next edge. A preload write while running leaves the count unchanged and takes effect only at the next reload.
- R11: Mode code 00 holds the count even when the enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Clock-source tick for timer and capture modes |
| pin_i | input | 1 | External pin, asynchronous |
| mode_i | input | 2 | 00 hold, 01 timer, 10 event, 11 capture |
| edge_sel_i | input | 1 | Edge polarity select |
| psc_sel_i | input | 3 | Prescaler select, divide by 2^value |
| en_wr_i | input | 1 | Enable write strobe |
| en_val_i | input | 1 | Enable value written by en_wr_i |
| preload_wr_i | input | 1 | Preload write strobe |
| preload_i | input | 8 | Preload value |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| pfd_sel_i | input | 1 | Divider source: 0 own, 1 peer |
| peer_ovf_i | input | 1 | Overflow pulse of the partner timer |
| count_o | output | 8 | Current count |
| ovf_flag_o | output | 1 | Sticky overflow flag |
| ovf_pulse_o | output | 1 | One-cycle overflow event |
| pfd_o | output | 1 | Divider square-wave output |
| en_o | output | 1 | Enable, including the automatic clear |

## Verification
Tick-driven results are registered once. A tick presented before an edge moves the count, the flag and the divider output at that same edge. Pin-driven results travel two synchroniser flops and then the counter. An event or capture boundary set up before edge k therefore acts at edge k+2. The bench checks an event count both at k+1, where it must not have moved yet, and at k+2. Strobes such as enable, preload and flag clear act at the first edge after they are driven. The bench drives every input and samples every output on the falling clock edge, so each check reads the value settled by the preceding rising edge.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD    = 2'b00,
    MODE_TIMER   = 2'b01,
    MODE_EVENT   = 2'b10,
    MODE_CAPTURE = 2'b11
  } pt_mode_e;

  // Select the edge strobe matching a polarity: 0 picks rise, 1 picks fall.
  function automatic logic pick_edge(input logic pol, input logic rise,
                                     input logic fall);
    pick_edge = pol ? fall : rise;
  endfunction
endpackage

// File: rtl/pt_edge_sync.sv
module pt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level  = chain_q[STAGES-1];
  assign rise_o = level & ~prev_q;
  assign fall_o = ~level & prev_q;
endmodule

// File: rtl/pt_prescaler.sv
module pt_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             step_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  // Low bits that must all be set for a divided step: 2^sel - 1.
  function automatic logic [DIV_W-1:0] tap_mask(input logic [SEL_W-1:0] s);
    logic [DIV_W:0] one_hot;
    one_hot  = '0;
    one_hot[s] = 1'b1;
    tap_mask = DIV_W'(one_hot - 1'b1);
  endfunction

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = tap_mask(sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (!run_i)  div_q <= '0;
    else if (tick_i)  div_q <= div_q + 1'b1;
  end

  assign step_o = run_i & tick_i & ((div_q & mask) == mask);
endmodule

// File: rtl/pt_counter.sv
module pt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  // Next value for one step: wrap to the reload value past all-ones.
  function automatic logic [CNT_W-1:0] stepped(input logic [CNT_W-1:0] c,
                                               input logic [CNT_W-1:0] r);
    stepped = (c == {CNT_W{1'b1}}) ? r : c + 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= reload_i;
    else if (step_i) cnt_q <= stepped(cnt_q, reload_i);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = step_i & (cnt_q == {CNT_W{1'b1}});
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CNT_W   = 8,
  parameter int SEL_W   = 3,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             pin_i,
  input  logic [1:0]       mode_i,
  input  logic             edge_sel_i,
  input  logic [SEL_W-1:0] psc_sel_i,
  input  logic             en_wr_i,
  input  logic             en_val_i,
  input  logic             preload_wr_i,
  input  logic [CNT_W-1:0] preload_i,
  input  logic             ovf_clr_i,
  input  logic             pfd_sel_i,
  input  logic             peer_ovf_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_flag_o,
  output logic             ovf_pulse_o,
  output logic             pfd_o,
  output logic             en_o
);
  import pt_pkg::*;

  pt_mode_e         mode;
  logic             en_q, meas_q, flag_q, pfd_q;
  logic [CNT_W-1:0] preload_q, reload_src;
  logic             pin_rise, pin_fall;
  logic             psc_run, psc_step;
  logic             is_cap, start_evt, stop_evt;
  logic             direct_load, cnt_step, wrap, pfd_src;

  assign mode   = pt_mode_e'(mode_i);
  assign is_cap = (mode == MODE_CAPTURE);

  pt_edge_sync #(.STAGES(SYNC_ST)) sync_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .rise_o(pin_rise), .fall_o(pin_fall)
  );

  assign psc_run = en_q & ((mode == MODE_TIMER) | is_cap);

  pt_prescaler #(.SEL_W(SEL_W)) psc_i (
    .clk(clk), .rst_n(rst_n), .run_i(psc_run), .tick_i(tick_i),
    .sel_i(psc_sel_i), .step_o(psc_step)
  );

  // Capture window boundaries.
  assign start_evt = is_cap & en_q & ~meas_q &
                     pick_edge(~edge_sel_i, pin_rise, pin_fall);
  assign stop_evt  = is_cap & en_q & meas_q &
                     pick_edge(edge_sel_i, pin_rise, pin_fall);

  always_comb begin
    unique case (mode)
      MODE_TIMER:   cnt_step = psc_step;
      MODE_EVENT:   cnt_step = en_q & pick_edge(edge_sel_i, pin_rise, pin_fall);
      MODE_CAPTURE: cnt_step = psc_step & (meas_q | start_evt) & ~stop_evt;
      default:      cnt_step = 1'b0;
    endcase
  end

  assign direct_load = preload_wr_i & ~en_q;
  assign reload_src  = direct_load ? preload_i : preload_q;

  pt_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst_n(rst_n), .load_i(direct_load), .step_i(cnt_step),
    .reload_i(reload_src), .cnt_o(count_o), .wrap_o(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preload_q <= '0;
      en_q      <= 1'b0;
      meas_q    <= 1'b0;
      flag_q    <= 1'b0;
      pfd_q     <= 1'b0;
    end else begin
      if (preload_wr_i) preload_q <= preload_i;

      if (en_wr_i)       en_q <= en_val_i;
      else if (stop_evt) en_q <= 1'b0;

      if (!en_q || !is_cap || stop_evt) meas_q <= 1'b0;
      else if (start_evt)               meas_q <= 1'b1;

      if (wrap)           flag_q <= 1'b1;
      else if (ovf_clr_i) flag_q <= 1'b0;

      if (pfd_src) pfd_q <= ~pfd_q;
    end
  end

  assign pfd_src     = pfd_sel_i ? peer_ovf_i : wrap;
  assign ovf_pulse_o = wrap;
  assign ovf_flag_o  = flag_q;
  assign pfd_o       = pfd_q;
  assign en_o        = en_q;
endmodule

// File: rtl/pulse_timer_chk.sv
module pulse_timer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic             en_wr_i,
  input logic             preload_wr_i,
  input logic             ovf_clr_i,
  input logic             pfd_sel_i,
  input logic             peer_ovf_i,
  input logic [CNT_W-1:0] count_o,
  input logic             ovf_flag_o,
  input logic             ovf_pulse_o,
  input logic             pfd_o,
  input logic             en_o,
  input logic [CNT_W-1:0] preload_q,
  input logic             stop_evt
);
  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !en_wr_i && !preload_wr_i) |=> $stable(count_o));

  // R11
  hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 2'b00 && !preload_wr_i) |=> $stable(count_o));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> (count_o == $past(preload_q)));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse_o |=> ovf_flag_o);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag_o && !ovf_clr_i) |=> ovf_flag_o);

  // R8
  pfd_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_sel_i ? peer_ovf_i : ovf_pulse_o) |=> (pfd_o != $past(pfd_o)));

  // R8
  pfd_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pfd_sel_i ? peer_ovf_i : ovf_pulse_o) |=> $stable(pfd_o));

  // R5
  cap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !en_wr_i) |=> !en_o);

  // R5
  cap_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(count_o));
endmodule

bind pulse_timer pulse_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .en_wr_i(en_wr_i),
  .preload_wr_i(preload_wr_i), .ovf_clr_i(ovf_clr_i), .pfd_sel_i(pfd_sel_i),
  .peer_ovf_i(peer_ovf_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
  .ovf_pulse_o(ovf_pulse_o), .pfd_o(pfd_o), .en_o(en_o),
  .preload_q(preload_q), .stop_evt(stop_evt)
);

// File: tb/pulse_timer_tb_top.sv
module pulse_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0, pin_i = 1'b0, edge_sel_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [2:0] psc_sel_i = 3'd0;
  logic       en_wr_i = 1'b0, en_val_i = 1'b0, preload_wr_i = 1'b0;
  logic [7:0] preload_i = 8'd0;
  logic       ovf_clr_i = 1'b0, pfd_sel_i = 1'b0, peer_ovf_i = 1'b0;
  logic [7:0] count_o;
  logic       ovf_flag_o, ovf_pulse_o, pfd_o, en_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pulse_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .pin_i(pin_i),
    .mode_i(mode_i), .edge_sel_i(edge_sel_i), .psc_sel_i(psc_sel_i),
    .en_wr_i(en_wr_i), .en_val_i(en_val_i), .preload_wr_i(preload_wr_i),
    .preload_i(preload_i), .ovf_clr_i(ovf_clr_i), .pfd_sel_i(pfd_sel_i),
    .peer_ovf_i(peer_ovf_i), .count_o(count_o), .ovf_flag_o(ovf_flag_o),
    .ovf_pulse_o(ovf_pulse_o), .pfd_o(pfd_o), .en_o(en_o)
  );

  // Timer vectors: {prescaler select, tick count, expected count}.
  localparam logic [19:0] TVEC [7] = '{
    {3'd0, 9'd5,   8'd5},
    {3'd1, 9'd7,   8'd3},
    {3'd2, 9'd9,   8'd2},
    {3'd3, 9'd20,  8'd2},
    {3'd4, 9'd50,  8'd3},
    {3'd5, 9'd64,  8'd2},
    {3'd7, 9'd200, 8'd1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_en(input logic v);
    en_wr_i = 1'b1; en_val_i = v; cyc(1); en_wr_i = 1'b0;
  endtask

  task automatic set_pre(input logic [7:0] v);
    preload_wr_i = 1'b1; preload_i = v; cyc(1); preload_wr_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_i = 1'b1; cyc(n); tick_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 flag", ovf_flag_o, 0);
    chk("R1 pfd", pfd_o, 0);
    chk("R1 en", en_o, 0);

    // R2 table walk
    mode_i = 2'b01;
    foreach (TVEC[i]) begin
      set_en(1'b0);
      set_pre(8'd0);
      psc_sel_i = TVEC[i][19:17];
      set_en(1'b1);
      ticks(int'(TVEC[i][16:8]));
      set_en(1'b0);
      chk("R2 prescaled count", count_o, int'(TVEC[i][7:0]));
    end

    // R9 stopped timer ignores ticks
    psc_sel_i = 3'd0;
    ticks(10);
    chk("R9 timer off", count_o, 1);

    // R11 hold mode ignores ticks while enabled
    mode_i = 2'b00;
    set_en(1'b1);
    ticks(10);
    chk("R11 hold mode", count_o, 1);
    set_en(1'b0);

    // R3 event counting and latency
    mode_i = 2'b10; edge_sel_i = 1'b0;
    set_pre(8'd0);
    pin_i = 1'b1; cyc(4); pin_i = 1'b0; cyc(4);
    chk("R9 event off", count_o, 0);
    set_en(1'b1);
    pin_i = 1'b1; cyc(2);
    chk("R3 not yet at k+1", count_o, 0);
    cyc(1);
    chk("R3 rise at k+2", count_o, 1);
    cyc(1); pin_i = 1'b0; cyc(4);
    chk("R3 fall ignored sel0", count_o, 1);
    edge_sel_i = 1'b1;
    pin_i = 1'b1; cyc(4);
    chk("R3 rise ignored sel1", count_o, 1);
    pin_i = 1'b0; cyc(4);
    chk("R3 fall counted sel1", count_o, 2);
    for (int p = 0; p < 3; p++) begin
      pin_i = 1'b1; cyc(3); pin_i = 1'b0; cyc(3);
    end
    chk("R3 three falls", count_o, 5);
    set_en(1'b0);

    // R4 capture, edge 0: low pulse of 10 cycles
    mode_i = 2'b11; edge_sel_i = 1'b0; psc_sel_i = 3'd0; tick_i = 1'b1;
    set_pre(8'd0);
    pin_i = 1'b1; cyc(4);
    set_en(1'b1); cyc(2);
    pin_i = 1'b0; cyc(10); pin_i = 1'b1; cyc(5);
    chk("R4 low pulse width", count_o, 10);
    chk("R5 enable auto clear", en_o, 0);
    pin_i = 1'b0; cyc(5); pin_i = 1'b1; cyc(5);
    chk("R5 count holds after end", count_o, 10);

    // R4 capture, edge 1: high pulse of 6 cycles
    edge_sel_i = 1'b1;
    set_pre(8'd0);
    pin_i = 1'b0; cyc(4);
    set_en(1'b1); cyc(2);
    pin_i = 1'b1; cyc(6); pin_i = 1'b0; cyc(5);
    chk("R4 high pulse width", count_o, 6);
    chk("R5 enable auto clear sel1", en_o, 0);
    tick_i = 1'b0;

    // R6 / R7 / R8 / R10 overflow
    mode_i = 2'b01; psc_sel_i = 3'd0; pfd_sel_i = 1'b0;
    set_pre(8'hFC);
    chk("R10 load while stopped", count_o, 8'hFC);
    set_en(1'b1);
    ticks(3);
    chk("R6 before wrap", count_o, 8'hFF);
    chk("R6 flag before wrap", ovf_flag_o, 0);
    ticks(1);
    chk("R6 reload", count_o, 8'hFC);
    chk("R6 flag set", ovf_flag_o, 1);
    chk("R8 pfd toggled", pfd_o, 1);
    set_pre(8'h10);
    chk("R10 no load while running", count_o, 8'hFC);
    ticks(1);
    chk("R7 flag sticky", ovf_flag_o, 1);
    ovf_clr_i = 1'b1; cyc(1); ovf_clr_i = 1'b0;
    chk("R7 flag cleared", ovf_flag_o, 0);
    ticks(2);
    chk("R6 at max again", count_o, 8'hFF);
    tick_i = 1'b1; ovf_clr_i = 1'b1; cyc(1); tick_i = 1'b0; ovf_clr_i = 1'b0;
    chk("R10 new preload used", count_o, 8'h10);
    chk("R7 set beats clear", ovf_flag_o, 1);
    chk("R8 pfd toggled back", pfd_o, 0);

    // R8 peer source
    pfd_sel_i = 1'b1;
    peer_ovf_i = 1'b1; cyc(1); peer_ovf_i = 1'b0;
    chk("R8 peer toggles", pfd_o, 1);
    set_en(1'b0);
    set_pre(8'hFF);
    set_en(1'b1);
    ticks(1);
    chk("R6 wrap to FF", count_o, 8'hFF);
    chk("R8 own ignored with peer", pfd_o, 1);
    pfd_sel_i = 1'b0;
    peer_ovf_i = 1'b1; cyc(1); peer_ovf_i = 1'b0;
    chk("R8 peer ignored with own", pfd_o, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule